// File: doc/BRIEF.md
# Rounding Accumulating Vector Right Shifter

This block shifts every lane of a packed vector right by an immediate amount, in one registered stage. The lane width is chosen per operation (8, 16, 32 or 64 bits). The shift is arithmetic or logical. Two further steps can be added on top of the plain shift. The first rounds the result by adding back the last bit shifted out. The second accumulates the result into the matching lane of a second operand vector.

The operation can act on the full vector or on only its low 64 bits. A scalar form computes lane 0 only. Lanes outside the selected form come out as zero. A controller presents the operands, the controls and a one-cycle `in_valid` strobe. The result appears on the next clock edge, marked by `out_valid`, and stays unchanged until the next strobe.

Top module: `vshr_round_acc`

## Requirements
- R1: `lane_sz` selects the lane width as 8 << `lane_sz`: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Lane k occupies bits [k*w +: w] of the vector.
- R2: With `is_signed` high, each lane is shifted arithmetically by `shamt`. With it low, each lane is shifted logically. `shamt` must lie from 1 to the lane width.
- R3: With `do_round` high, bit (`shamt`-1) of the source lane is added to the shifted lane.
- R4: With `do_acc` high, the lane of `dst` is added to the shifted (and possibly rounded) lane. The sum wraps modulo 2^lane width.
- R5: With `wide` low, only the low 64 bits hold lanes (64/w of them), and result bits [127:64] are zero.
- R6: With `scalar` high, only lane 0 is computed, every other result bit is zero, and `wide` has no effect.
- R7: For 64-bit lanes, the rounding increment keeps its carry into the upper part of the lane. For example, unsigned all-ones shifted by 1 and rounded gives 0x8000_0000_0000_0000.
- R8: `out_valid` is high in exactly the cycle after an `in_valid` cycle. `result` changes only on a clock edge where `in_valid` was high and otherwise holds.
- R9: A shift equal to the lane width gives all sign bits (signed) or zero (unsigned) before rounding. With rounding, the lane MSB is then added.
- R10: After reset, `out_valid` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| src | input | 128 | Vector to be shifted |
| dst | input | 128 | Accumulation operand vector |
| lane_sz | input | 2 | Lane width code |
| shamt | input | 7 | Right shift amount, 1 to lane width |
| is_signed | input | 1 | Arithmetic (1) or logical (0) shift |
| do_round | input | 1 | Add the last bit shifted out |
| do_acc | input | 1 | Add the `dst` lane |
| scalar | input | 1 | Compute lane 0 only |
| wide | input | 1 | 128-bit (1) or 64-bit (0) vector |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 128 | Registered result vector |

## Verification
Rounding and accumulation can both land in the same lane in the same cycle. The two increments then stack, and a carry must wrap at the lane width instead of leaking into the next lane. The bench provokes this case with all-ones sources and large `dst` lanes, together with shift amounts equal to the lane width, where the rounding bit is the lane MSB. Each result is judged against a bench model that works on sign-extended 65-bit integers, with every lane size, signedness and form tried in turn.

// File: rtl/vshr_round_acc.sv
module vshr_round_acc #(
  parameter int VEC_W = 128,
  parameter int SH_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] src,
  input  logic [VEC_W-1:0] dst,
  input  logic [1:0]       lane_sz,
  input  logic [SH_W-1:0]  shamt,
  input  logic             is_signed,
  input  logic             do_round,
  input  logic             do_acc,
  input  logic             scalar,
  input  logic             wide,
  output logic             out_valid,
  output logic [VEC_W-1:0] result
);
  localparam int NSZ = 4;

  logic [NSZ-1:0][VEC_W-1:0] per_sz;
  logic [VEC_W-1:0]          nxt;

  for (genvar s = 0; s < NSZ; s++) begin : g_sz
    localparam int EW = 8 << s;
    localparam int NL = VEC_W / EW;
    logic [SH_W-1:0] lsh;
    assign lsh = SH_W'(EW) - shamt;

    for (genvar i = 0; i < NL; i++) begin : g_lane
      logic [EW-1:0]        a, d, rtmp, sum;
      logic signed [EW:0]   ext, shd;
      logic                 rb, act;

      assign a    = src[i*EW +: EW];
      assign d    = dst[i*EW +: EW];
      assign ext  = {is_signed & a[EW-1], a};
      assign shd  = ext >>> shamt;
      assign rtmp = a << lsh;
      assign rb   = do_round & rtmp[EW-1];
      assign sum  = shd[EW-1:0] + EW'(rb) + (do_acc ? d : '0);

      if (i == 0) begin : g_first
        assign act = 1'b1;
      end else if (i < NL / 2) begin : g_low
        assign act = !scalar;
      end else begin : g_high
        assign act = !scalar && wide;
      end

      assign per_sz[s][i*EW +: EW] = act ? sum : '0;
    end
  end

  assign nxt = per_sz[lane_sz];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end
endmodule

// File: rtl/vshr_round_acc_chk.sv
module vshr_round_acc_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [1:0]   lane_sz,
  input logic [6:0]   shamt,
  input logic         is_signed,
  input logic         do_round,
  input logic         do_acc,
  input logic         scalar,
  input logic         wide,
  input logic         out_valid,
  input logic [127:0] result
);
  p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide) |=> result[127:64] == 64'd0);
  p_scalar_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && scalar && lane_sz == 2'd0) |=> result[127:8] == 120'd0);
  p_full_shift_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_sz == 2'd3 && shamt == 7'd64 && !is_signed && !do_round && !do_acc)
    |=> result == 128'd0);
endmodule

bind vshr_round_acc vshr_round_acc_chk i_chk (.*);

// File: tb/test_vshr_round_acc.sv
`timescale 1ns/100ps
module test_vshr_round_acc;
  logic         clk = 0, rst_n = 0, in_valid = 0;
  logic [127:0] src = '0, dst = '0;
  logic [1:0]   lane_sz = 0;
  logic [6:0]   shamt = 1;
  logic         is_signed = 0, do_round = 0, do_acc = 0, scalar = 0, wide = 1;
  logic         out_valid;
  logic [127:0] result;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  vshr_round_acc i_vshr_round_acc (.*);

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not end");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] model(logic [127:0] s, logic [127:0] d, int sz, int sh,
                                         bit sg, bit rn, bit ac, bit sc, bit wd);
    logic [127:0] r = '0;
    int ew = 8 << sz;
    int nl = sc ? 1 : ((wd ? 128 : 64) / ew);
    for (int i = 0; i < nl; i++) begin
      logic signed [64:0] a = '0;
      logic [64:0] dd = '0, tot;
      for (int b = 0; b < ew; b++) begin a[b] = s[i*ew+b]; dd[b] = d[i*ew+b]; end
      if (sg && a[ew-1]) for (int b = ew; b < 65; b++) a[b] = 1'b1;
      tot = 65'(a >>> sh);
      if (rn) tot = tot + 65'(a[sh-1]);
      if (ac) tot = tot + dd;
      for (int b = 0; b < ew; b++) r[i*ew+b] = tot[b];
    end
    return r;
  endfunction

  task automatic op(logic [127:0] s, logic [127:0] d, int sz, int sh,
                    bit sg, bit rn, bit ac, bit sc, bit wd);
    @(negedge clk);
    src = s; dst = d; lane_sz = 2'(sz); shamt = 7'(sh);
    is_signed = sg; do_round = rn; do_acc = ac; scalar = sc; wide = wd; in_valid = 1;
    @(posedge clk); #1;
    chk("R8 valid", {127'd0, out_valid}, 128'd1);
    @(negedge clk); in_valid = 0;
  endtask

  task automatic t_reset;
    #1;
    chk("R10 result", result, '0);
    chk("R10 valid", {127'd0, out_valid}, '0);
  endtask

  task automatic t_basic;
    op({16{8'h80}}, '0, 0, 3, 0, 0, 0, 0, 1);
    chk("R1 R2 logical byte", result, {16{8'h10}});
    op({16{8'h80}}, '0, 0, 3, 1, 0, 0, 0, 1);
    chk("R2 arith byte", result, {16{8'hF0}});
    op({8{16'h8000}}, '0, 1, 4, 1, 0, 0, 0, 1);
    chk("R1 halfword", result, {8{16'hF800}});
  endtask

  task automatic t_round;
    op({16{8'h07}}, '0, 0, 2, 0, 1, 0, 0, 1);
    chk("R3 round unsigned", result, {16{8'h02}});
    op({16{8'hF9}}, '0, 0, 1, 1, 1, 0, 0, 1);
    chk("R3 round signed", result, {16{8'hFD}});
  endtask

  task automatic t_acc;
    op({16{8'hFF}}, {16{8'h90}}, 0, 1, 0, 0, 1, 0, 1);
    chk("R4 acc wrap", result, {16{8'h0F}});
    op({16{8'hFF}}, {16{8'hFF}}, 0, 8, 0, 1, 1, 0, 1);
    chk("R4 R3 round+acc wrap", result, '0);
  endtask

  task automatic t_half;
    op({128{1'b1}}, '0, 2, 4, 0, 0, 0, 0, 0);
    chk("R5 upper zero", result, {64'd0, {2{32'h0FFFFFFF}}});
  endtask

  task automatic t_scalar;
    op({128{1'b1}}, '0, 0, 1, 0, 0, 0, 1, 1);
    chk("R6 scalar lane0", result, {120'd0, 8'h7F});
  endtask

  task automatic t_r7;
    op({128{1'b1}}, '0, 3, 1, 0, 1, 0, 0, 1);
    chk("R7 carry 64", result, {2{64'h8000_0000_0000_0000}});
  endtask

  task automatic t_full;
    op({16{8'h80}}, '0, 0, 8, 1, 0, 0, 0, 1);
    chk("R9 sign fill", result, {128{1'b1}});
    op({16{8'h80}}, '0, 0, 8, 0, 0, 0, 0, 1);
    chk("R9 zero", result, '0);
    op({16{8'h80}}, '0, 0, 8, 1, 1, 0, 0, 1);
    chk("R9 signed round", result, '0);
  endtask

  task automatic t_hold;
    logic [127:0] keep;
    op({16{8'h40}}, '0, 0, 1, 0, 0, 0, 0, 1);
    keep = result;
    src = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 hold", result, keep);
    chk("R8 valid low", {127'd0, out_valid}, '0);
  endtask

  task automatic t_sweep;
    logic [127:0] pats[3];
    pats[0] = 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F;
    pats[1] = 128'h8000_7FFF_FFFF_0001_8000_0000_0000_0001;
    pats[2] = 128'hFFFF_FFFF_FFFF_FFFF_8888_8888_7777_7777;
    for (int p = 0; p < 3; p++)
      for (int sz = 0; sz < 4; sz++)
        for (int m = 0; m < 8; m++) begin
          int sh = (m % 2) ? (8 << sz) : 1 + (p * 3 + m) % (8 << sz);
          op(pats[p], pats[(p + 1) % 3], sz, sh, m[0], m[1], m[2], (m == 5), (m != 6));
          chk("R1 R2 R3 R4 R5 R6 R9 sweep", result,
              model(pats[p], pats[(p + 1) % 3], sz, sh, m[0], m[1], m[2], (m == 5), (m != 6)));
        end
  endtask

  initial begin
    t_reset;
    #20; rst_n = 1;
    t_basic;
    t_round;
    t_acc;
    t_half;
    t_scalar;
    t_r7;
    t_full;
    t_hold;
    t_sweep;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule